// File: doc/BRIEF.md
# Quad SPI Master Register and FIFO Port

This block is the bus-facing front end of a quad SPI master. A processor reaches it over a simple 32-bit register bus with an address, a write strobe, a read strobe, write data, read data and a wait signal. It holds the configuration for the serial engine: enable, master select, clock idle level, lane width, lane mode and clock divider. It also holds the frame description, which gives the total byte count, the command byte count, the multi-line flag, the idle cycles and the byte/word flags. These settings are driven out as plain configuration outputs to a frame sequencer.

Two byte FIFOs sit between the bus and the sequencer, one for transmit and one for receive. Software reaches each FIFO through two windows. A word window moves four bytes per access, with the first byte on the serial side placed in bits 7:0. A byte window moves a single byte in bits 7:0. When a window cannot complete, the block stretches the access with `bus_wait` rather than losing data.

Events from the sequencer are latched as sticky status bits, which software clears by writing ones. A single interrupt line reports any status bit whose enable bit is set. Writing the frame register while the sequencer reports ready starts a frame. Clearing the enable bit empties both FIFOs and aborts the frame in progress.

Top module: `qspi_regport`

## Requirements
- R1: After reset every register reads zero. The status register reads 0x98 while `seq_ready` is high, and `irq` is low. Register offsets are 0x00 control, 0x04 frame, 0x0C interrupt enable, 0x10 status and 0x50 frame-upper. Control keeps only bits 0, 1, 10, 13, 14, 15, 16 and 27:24, the enable register keeps bits 5:0, and frame-upper keeps bits 31:16. All of these read back what was written through those masks.
- R2: The control fields drive the configuration outputs: bit 0 is enable, bit 1 is master, bit 10 is clock idle, bit 13 is quad width, bits 15:14 are lane mode and bits 27:24 are the divider. The frame fields drive the frame outputs. The total byte count is frame-upper bits 31:16 joined above frame bits 15:0. The command byte count is bits 24:16, the multi-line flag is bit 25, idle cycles are bits 29:26, and `frm_flags` is {bit 31, bit 30}.
- R3: The live status bits follow the FIFOs and inputs at every cycle. Bit 3 is set while transmit has a free entry, bit 4 while receive is empty, and bit 5 while transmit is full. Bit 7 mirrors `seq_ready`, and bit 8 mirrors control bit 16.
- R4: A one-cycle pulse on `ev_tx_done`, `ev_rx_done` or `ev_rx_avail` sets status bit 0, 1 or 2 respectively, and the bit stays set.
- R5: A status write clears each of bits 2:0 that it writes as one and leaves each bit written as zero unchanged.
- R6: `irq` is high exactly when some status bit in 5:0 is set together with the same bit of the enable register.
- R7: A write to 0x4C pushes four bytes into the transmit FIFO. The byte in bits 7:0 is sent first and the byte in bits 31:24 is sent last.
- R8: A read from 0x48 pops four bytes from the receive FIFO. The first byte received appears in bits 7:0.
- R9: A write to 0x44 pushes only bits 7:0 as one byte. A read from 0x40 pops one byte, returned in bits 7:0 with zeros above.
- R10: Each FIFO holds 16 bytes. `bus_wait` is asserted in four cases: a word push while fewer than four entries are free, a byte push while the transmit FIFO is full, a word pop while fewer than four bytes are held, and a byte pop while the receive FIFO is empty.
- R11: A frame register write accepted while enabled and while `seq_ready` is high gives a single-cycle `frm_start` pulse one cycle later. A frame write made while `seq_ready` is low gives no pulse.
- R12: While the enable bit is clear, both FIFOs are held empty. Writing control with bit 0 clear while enabled gives a single-cycle `frm_abort` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 8 | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while the read strobe is high |
| bus_wait | output | 1 | Stretches the current access |
| irq | output | 1 | Interrupt request |
| cfg_enable | output | 1 | Controller enable |
| cfg_master | output | 1 | Master select |
| cfg_clk_idle | output | 1 | Serial clock idle level |
| cfg_quad | output | 1 | Four-lane data width select |
| cfg_lane_mode | output | 2 | Lane mode for command, address and data |
| cfg_clk_div | output | 4 | Serial clock divider |
| frm_total | output | 32 | Total bytes in the frame |
| frm_cmd_bytes | output | 9 | Command bytes in the frame |
| frm_multi | output | 1 | Multi-line frame flag |
| frm_idle | output | 4 | Idle cycles |
| frm_flags | output | 2 | Word flag, byte flag |
| frm_start | output | 1 | Frame start pulse |
| frm_abort | output | 1 | Frame abort pulse |
| tx_byte | output | 8 | Head byte of the transmit FIFO |
| tx_valid | output | 1 | Transmit FIFO not empty |
| tx_take | input | 1 | Sequencer takes the head byte |
| rx_byte | input | 8 | Received byte |
| rx_push | input | 1 | Received byte is valid |
| rx_ready | output | 1 | Receive FIFO can accept a byte |
| seq_ready | input | 1 | Sequencer idle and ready |
| ev_tx_done | input | 1 | Transmit done event |
| ev_rx_done | input | 1 | Receive done event |
| ev_rx_avail | input | 1 | Receive data available event |

## Verification
Register masking is checked with all-ones and with sparse words. These patterns separate writable bits from reserved bits, and the frame-upper half from the low half. Byte order is checked with a word holding four distinct byte values sent through a loopback model, which catches lane swaps in either direction. A pair of byte-window writes with junk in the upper bits shows whether only the low byte is taken. The FIFO is filled exactly to 16 entries, and the receive side is left holding 3 bytes, to probe the wait threshold at each edge. Status clears are tried with ones on the wrong bits and then on the right bit, which shows whether a zero bit is left alone. The interrupt is checked with the enable bit on and off, which shows the masking.

// File: rtl/qspi_regport_pkg.sv
package qspi_regport_pkg;

  localparam logic [7:0] OFS_CTRL   = 8'h00;
  localparam logic [7:0] OFS_FRAMES = 8'h04;
  localparam logic [7:0] OFS_IEN    = 8'h0C;
  localparam logic [7:0] OFS_STAT   = 8'h10;
  localparam logic [7:0] OFS_RXB    = 8'h40;
  localparam logic [7:0] OFS_TXB    = 8'h44;
  localparam logic [7:0] OFS_RXW    = 8'h48;
  localparam logic [7:0] OFS_TXW    = 8'h4C;
  localparam logic [7:0] OFS_FUP    = 8'h50;

  typedef struct packed {
    logic [3:0] div;
    logic       x4;
    logic [1:0] mode;
    logic       quad;
    logic       clk_idle;
    logic       master;
    logic       enable;
  } ctrl_t;

  function automatic ctrl_t ctrl_from_word(input logic [31:0] w);
    ctrl_t c;
    c.div      = w[27:24];
    c.x4       = w[16];
    c.mode     = w[15:14];
    c.quad     = w[13];
    c.clk_idle = w[10];
    c.master   = w[1];
    c.enable   = w[0];
    return c;
  endfunction

  function automatic logic [31:0] ctrl_to_word(input ctrl_t c);
    logic [31:0] w;
    w        = '0;
    w[27:24] = c.div;
    w[16]    = c.x4;
    w[15:14] = c.mode;
    w[13]    = c.quad;
    w[10]    = c.clk_idle;
    w[1]     = c.master;
    w[0]     = c.enable;
    return w;
  endfunction

  // sticky event bits: a new event wins over a clear in the same cycle
  function automatic logic [2:0] sticky_next(input logic [2:0] cur,
                                             input logic [2:0] set,
                                             input logic [2:0] clr);
    return set | (cur & ~clr);
  endfunction

  function automatic logic [31:0] status_word(input logic [2:0] sticky,
                                              input logic tx_avail,
                                              input logic rx_empty,
                                              input logic tx_full,
                                              input logic ready,
                                              input logic x4);
    logic [31:0] w;
    w      = '0;
    w[2:0] = sticky;
    w[3]   = tx_avail;
    w[4]   = rx_empty;
    w[5]   = tx_full;
    w[7]   = ready;
    w[8]   = x4;
    return w;
  endfunction

  function automatic logic irq_of(input logic [5:0] st, input logic [5:0] en);
    return |(st & en);
  endfunction

endpackage

// File: rtl/qspi_byte_fifo.sv
module qspi_byte_fifo #(
  parameter int DEPTH    = 16,
  parameter int WR_LANES = 4,
  parameter int RD_LANES = 1,
  localparam int AW  = $clog2(DEPTH),
  localparam int CW  = $clog2(DEPTH + 1),
  localparam int NWW = $clog2(WR_LANES + 1),
  localparam int NWR = $clog2(RD_LANES + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic [NWW-1:0]        push_n,
  input  logic [8*WR_LANES-1:0] push_data,
  input  logic [NWR-1:0]        pop_n,
  output logic [8*RD_LANES-1:0] peek,
  output logic [CW-1:0]         count
);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr + AW'(push_n);
      rd_ptr <= rd_ptr + AW'(pop_n);
      count  <= count + CW'(push_n) - CW'(pop_n);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < WR_LANES; i++) begin
      if (!flush && i < int'(push_n))
        mem[AW'(wr_ptr + AW'(i))] <= push_data[8*i +: 8];
    end
  end

  for (genvar g = 0; g < RD_LANES; g++) begin : g_peek
    assign peek[8*g +: 8] = mem[AW'(rd_ptr + AW'(g))];
  end

endmodule

// File: rtl/qspi_ctrl_regs.sv
module qspi_ctrl_regs
  import qspi_regport_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  addr,
  input  logic [31:0] wdata,
  input  logic [2:0]  ev_set,
  input  logic        seq_ready,
  output ctrl_t       ctrl,
  output logic [31:0] frames,
  output logic [15:0] fup,
  output logic [5:0]  ien,
  output logic [2:0]  sticky,
  output logic        frm_start,
  output logic        frm_abort
);

  logic       wr_ctrl, wr_frames, wr_stat;
  logic [2:0] clr;

  assign wr_ctrl   = wr_en && addr == OFS_CTRL;
  assign wr_frames = wr_en && addr == OFS_FRAMES;
  assign wr_stat   = wr_en && addr == OFS_STAT;
  assign clr       = wr_stat ? wdata[2:0] : 3'b000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl      <= '0;
      frames    <= '0;
      fup       <= '0;
      ien       <= '0;
      sticky    <= '0;
      frm_start <= 1'b0;
      frm_abort <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl <= ctrl_from_word(wdata);
      if (wr_frames) frames <= wdata;
      if (wr_en && addr == OFS_FUP) fup <= wdata[31:16];
      if (wr_en && addr == OFS_IEN) ien <= wdata[5:0];
      sticky    <= sticky_next(sticky, ev_set, clr);
      frm_start <= wr_frames && seq_ready && ctrl.enable;
      frm_abort <= wr_ctrl && ctrl.enable && !wdata[0];
    end
  end

endmodule

// File: rtl/qspi_regport.sv
module qspi_regport
  import qspi_regport_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        bus_wait,
  output logic        irq,
  output logic        cfg_enable,
  output logic        cfg_master,
  output logic        cfg_clk_idle,
  output logic        cfg_quad,
  output logic [1:0]  cfg_lane_mode,
  output logic [3:0]  cfg_clk_div,
  output logic [31:0] frm_total,
  output logic [8:0]  frm_cmd_bytes,
  output logic        frm_multi,
  output logic [3:0]  frm_idle,
  output logic [1:0]  frm_flags,
  output logic        frm_start,
  output logic        frm_abort,
  output logic [7:0]  tx_byte,
  output logic        tx_valid,
  input  logic        tx_take,
  input  logic [7:0]  rx_byte,
  input  logic        rx_push,
  output logic        rx_ready,
  input  logic        seq_ready,
  input  logic        ev_tx_done,
  input  logic        ev_rx_done,
  input  logic        ev_rx_avail
);

  localparam int LANES = 4;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] WORD_CNT = CW'(LANES);

  ctrl_t       ctrl;
  logic [31:0] frames;
  logic [15:0] fup;
  logic [5:0]  ien;
  logic [2:0]  sticky;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [31:0] rx_peek;
  logic [31:0] status;

  // named bus events, also observed by the checker
  logic wait_tx_word, wait_tx_byte, wait_rx_word, wait_rx_byte;
  logic wr_ok, rd_ok;
  logic [2:0] tx_in_n, rx_out_n;
  logic       tx_out_n, rx_in_n;

  assign wait_tx_word = bus_wr && bus_addr == OFS_TXW && (FULL_CNT - tx_cnt) < WORD_CNT;
  assign wait_tx_byte = bus_wr && bus_addr == OFS_TXB && tx_cnt == FULL_CNT;
  assign wait_rx_word = bus_rd && bus_addr == OFS_RXW && rx_cnt < WORD_CNT;
  assign wait_rx_byte = bus_rd && bus_addr == OFS_RXB && rx_cnt == '0;
  assign bus_wait = wait_tx_word | wait_tx_byte | wait_rx_word | wait_rx_byte;

  assign wr_ok = bus_wr && !bus_wait;
  assign rd_ok = bus_rd && !bus_wait;

  assign tx_in_n  = !wr_ok ? 3'd0 : bus_addr == OFS_TXW ? 3'd4 :
                    bus_addr == OFS_TXB ? 3'd1 : 3'd0;
  assign rx_out_n = !rd_ok ? 3'd0 : bus_addr == OFS_RXW ? 3'd4 :
                    bus_addr == OFS_RXB ? 3'd1 : 3'd0;
  assign tx_valid = tx_cnt != '0;
  assign tx_out_n = tx_take && tx_valid;
  assign rx_ready = rx_cnt != FULL_CNT;
  assign rx_in_n  = rx_push && rx_ready;

  qspi_ctrl_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_ok),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .ev_set    ({ev_rx_avail, ev_rx_done, ev_tx_done}),
    .seq_ready (seq_ready),
    .ctrl      (ctrl),
    .frames    (frames),
    .fup       (fup),
    .ien       (ien),
    .sticky    (sticky),
    .frm_start (frm_start),
    .frm_abort (frm_abort)
  );

  qspi_byte_fifo #(.DEPTH(DEPTH), .WR_LANES(LANES), .RD_LANES(1)) u_tx_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (!ctrl.enable),
    .push_n    (tx_in_n),
    .push_data (bus_wdata),
    .pop_n     (tx_out_n),
    .peek      (tx_byte),
    .count     (tx_cnt)
  );

  qspi_byte_fifo #(.DEPTH(DEPTH), .WR_LANES(1), .RD_LANES(LANES)) u_rx_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (!ctrl.enable),
    .push_n    (rx_in_n),
    .push_data (rx_byte),
    .pop_n     (rx_out_n),
    .peek      (rx_peek),
    .count     (rx_cnt)
  );

  assign status = status_word(sticky, tx_cnt != FULL_CNT, rx_cnt == '0,
                              tx_cnt == FULL_CNT, seq_ready, ctrl.x4);
  assign irq = irq_of(status[5:0], ien);

  always_comb begin
    case (bus_addr)
      OFS_CTRL:   bus_rdata = ctrl_to_word(ctrl);
      OFS_FRAMES: bus_rdata = frames;
      OFS_IEN:    bus_rdata = {26'b0, ien};
      OFS_STAT:   bus_rdata = status;
      OFS_RXB:    bus_rdata = {24'b0, rx_peek[7:0]};
      OFS_RXW:    bus_rdata = rx_peek;
      OFS_FUP:    bus_rdata = {fup, 16'b0};
      default:    bus_rdata = '0;
    endcase
  end

  assign cfg_enable    = ctrl.enable;
  assign cfg_master    = ctrl.master;
  assign cfg_clk_idle  = ctrl.clk_idle;
  assign cfg_quad      = ctrl.quad;
  assign cfg_lane_mode = ctrl.mode;
  assign cfg_clk_div   = ctrl.div;
  assign frm_total     = {fup, frames[15:0]};
  assign frm_cmd_bytes = frames[24:16];
  assign frm_multi     = frames[25];
  assign frm_idle      = frames[29:26];
  assign frm_flags     = frames[31:30];

endmodule

// File: rtl/qspi_regport_chk.sv
module qspi_regport_chk
  import qspi_regport_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [7:0]    bus_addr,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic          wdata0,
  input logic          bus_wait,
  input logic          seq_ready,
  input logic          ev_tx_done,
  input logic          ev_rx_done,
  input logic          cfg_enable,
  input logic          frm_start,
  input logic          rx_push,
  input logic          rx_ready,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt,
  input logic [2:0]    sticky
);

  p_word_push_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_TXW && tx_cnt > CW'(DEPTH - 4)) |-> bus_wait);

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt <= CW'(DEPTH)) && (rx_cnt <= CW'(DEPTH)));

  p_word_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wait && bus_addr == OFS_RXW && cfg_enable) |=>
      (rx_cnt == $past(rx_cnt) - CW'(4) + CW'($past(rx_push && rx_ready))));

  p_w1c_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_wait && bus_addr == OFS_STAT && wdata0 && !ev_tx_done) |=> !sticky[0]);

  p_event_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_done |=> sticky[1]);

  p_start_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    frm_start |-> $past(bus_wr && !bus_wait && bus_addr == OFS_FRAMES && seq_ready));

  p_flush_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> (tx_cnt == '0 && rx_cnt == '0));

endmodule

bind qspi_regport qspi_regport_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .wdata0     (bus_wdata[0]),
  .bus_wait   (bus_wait),
  .seq_ready  (seq_ready),
  .ev_tx_done (ev_tx_done),
  .ev_rx_done (ev_rx_done),
  .cfg_enable (cfg_enable),
  .frm_start  (frm_start),
  .rx_push    (rx_push),
  .rx_ready   (rx_ready),
  .tx_cnt     (tx_cnt),
  .rx_cnt     (rx_cnt),
  .sticky     (sticky)
);

// File: tb/test_qspi_regport.sv
module test_qspi_regport;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_wait, irq;
  logic        cfg_enable, cfg_master, cfg_clk_idle, cfg_quad;
  logic [1:0]  cfg_lane_mode;
  logic [3:0]  cfg_clk_div;
  logic [31:0] frm_total;
  logic [8:0]  frm_cmd_bytes;
  logic        frm_multi;
  logic [3:0]  frm_idle;
  logic [1:0]  frm_flags;
  logic        frm_start, frm_abort;
  logic [7:0]  tx_byte;
  logic        tx_valid;
  logic        tx_take = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        rx_push = 1'b0;
  logic        rx_ready;
  logic        seq_ready = 1'b1;
  logic [2:0]  ev = '0;

  qspi_regport i_qspi_regport (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_wait(bus_wait), .irq(irq),
    .cfg_enable(cfg_enable), .cfg_master(cfg_master), .cfg_clk_idle(cfg_clk_idle),
    .cfg_quad(cfg_quad), .cfg_lane_mode(cfg_lane_mode), .cfg_clk_div(cfg_clk_div),
    .frm_total(frm_total), .frm_cmd_bytes(frm_cmd_bytes), .frm_multi(frm_multi),
    .frm_idle(frm_idle), .frm_flags(frm_flags), .frm_start(frm_start),
    .frm_abort(frm_abort), .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_take(tx_take),
    .rx_byte(rx_byte), .rx_push(rx_push), .rx_ready(rx_ready), .seq_ready(seq_ready),
    .ev_tx_done(ev[0]), .ev_rx_done(ev[1]), .ev_rx_avail(ev[2])
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // loopback sequencer model
  logic       lb_on = 1'b0;
  logic [7:0] lb_log [32];
  int         lb_n = 0;
  int         n_start = 0;
  int         n_abort = 0;

  always @(negedge clk) begin
    logic take;
    take = lb_on && tx_valid && rx_ready;
    tx_take <= take;
    rx_push <= take;
    rx_byte <= tx_byte;
    if (take && lb_n < 32) begin
      lb_log[lb_n] <= tx_byte;
      lb_n <= lb_n + 1;
    end
    if (frm_start) n_start <= n_start + 1;
    if (frm_abort) n_abort <= n_abort + 1;
  end

  localparam logic [7:0] A_CTRL = 8'h00, A_FRM = 8'h04, A_IEN = 8'h0C, A_STAT = 8'h10;
  localparam logic [7:0] A_RXB = 8'h40, A_TXB = 8'h44, A_RXW = 8'h48, A_TXW = 8'h4C, A_FUP = 8'h50;

  // {address, write data, expected read-back}
  localparam int NVEC = 6;
  localparam logic [71:0] VEC [NVEC] = '{
    {A_CTRL, 32'hFFFF_FFFF, 32'h0F01_E403},
    {A_CTRL, 32'h0000_0003, 32'h0000_0003},
    {A_IEN,  32'hFFFF_FFFF, 32'h0000_003F},
    {A_IEN,  32'h0000_0000, 32'h0000_0000},
    {A_FUP,  32'hABCD_1234, 32'hABCD_0000},
    {A_FRM,  32'h8A5B_0010, 32'h8A5B_0010}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bwr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    #1;
    while (bus_wait) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic brd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    while (bus_wait) begin @(negedge clk); #1; end
    d = bus_rdata;
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic probe_wait(input logic [7:0] a, input logic is_wr, input string req);
    bus_addr = a; bus_wr = is_wr; bus_rd = !is_wr; bus_wdata = 32'hFFFF_FFFF;
    #1;
    chk(req, 32'(bus_wait), 32'd1);
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic pulse(input int idx);
    ev[idx] = 1'b1;
    @(negedge clk);
    ev = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int s0;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    brd(A_STAT, r); chk("R1 status after reset", r, 32'h0000_0098);
    brd(A_CTRL, r); chk("R1 control after reset", r, 32'h0);
    brd(A_FRM, r);  chk("R1 frames after reset", r, 32'h0);
    chk("R6 irq after reset", 32'(irq), 32'd0);

    // R1 register masks through the vector table
    for (int i = 0; i < NVEC; i++) begin
      bwr(VEC[i][71:64], VEC[i][63:32]);
      brd(VEC[i][71:64], r);
      chk($sformatf("R1 readback vector %0d", i), r, VEC[i][31:0]);
    end

    // R2 frame outputs
    chk("R2 total bytes", frm_total, 32'hABCD_0010);
    chk("R2 command bytes", 32'(frm_cmd_bytes), 32'h05B);
    chk("R2 multi/idle/flags", {25'b0, frm_multi, frm_idle, frm_flags}, {25'b0, 1'b1, 4'd2, 2'b10});

    // R2 control outputs, R3 word-access status bit
    bwr(A_CTRL, 32'h0A01_A403);
    chk("R2 control outputs",
        {20'b0, cfg_clk_div, cfg_lane_mode, cfg_quad, cfg_clk_idle, cfg_master, cfg_enable},
        {20'b0, 4'hA, 2'b10, 1'b1, 1'b1, 1'b1, 1'b1});
    brd(A_STAT, r); chk("R3 word flag in status bit 8", 32'(r[8]), 32'd1);
    bwr(A_CTRL, 32'h0000_0003);

    // R11 frame start with ready high and low
    s0 = n_start;
    bwr(A_FRM, 32'h0000_0004); idle(2);
    chk("R11 start pulse when ready", 32'(n_start - s0), 32'd1);
    seq_ready = 1'b0;
    brd(A_STAT, r); chk("R3 ready bit follows input", 32'(r[7]), 32'd0);
    s0 = n_start;
    bwr(A_FRM, 32'h0000_0008); idle(2);
    chk("R11 no start when not ready", 32'(n_start - s0), 32'd0);
    seq_ready = 1'b1;

    // R7 word transmit order, R8 word receive order
    bwr(A_TXW, 32'h4433_2211);
    lb_on = 1'b1; idle(8); lb_on = 1'b0; idle(2);
    chk("R7 four bytes sent", 32'(lb_n), 32'd4);
    chk("R7 byte order", {lb_log[3], lb_log[2], lb_log[1], lb_log[0]}, 32'h4433_2211);
    brd(A_RXW, r); chk("R8 word read order", r, 32'h4433_2211);
    brd(A_STAT, r); chk("R3 rx empty after word pop", 32'(r[4]), 32'd1);

    // R9 byte windows
    bwr(A_TXB, 32'h0000_01A5);
    bwr(A_TXB, 32'hFFFF_FF5A);
    lb_on = 1'b1; idle(6); lb_on = 1'b0; idle(2);
    chk("R9 only low byte pushed", 32'(lb_n), 32'd6);
    brd(A_RXB, r); chk("R9 first byte read", r, 32'h0000_00A5);
    brd(A_RXB, r); chk("R9 second byte read", r, 32'h0000_005A);

    // R10 receive word wait with three bytes held
    bwr(A_TXB, 32'h1); bwr(A_TXB, 32'h2); bwr(A_TXB, 32'h3);
    lb_on = 1'b1; idle(6); lb_on = 1'b0; idle(2);
    probe_wait(A_RXW, 1'b0, "R10 word pop waits with 3 bytes");
    brd(A_RXB, r); brd(A_RXB, r); brd(A_RXB, r);
    chk("R9 last byte of three", r, 32'h0000_0003);
    probe_wait(A_RXB, 1'b0, "R10 byte pop waits when empty");

    // R10 transmit fill to exactly 16 bytes
    for (int k = 0; k < 4; k++) bwr(A_TXW, 32'h1010_1010 * (k + 1));
    brd(A_STAT, r); chk("R3 tx full set, avail clear", {30'b0, r[5], r[3]}, {30'b0, 2'b10});
    probe_wait(A_TXW, 1'b1, "R10 word push waits when full");
    probe_wait(A_TXB, 1'b1, "R10 byte push waits when full");

    // R12 disable flushes and aborts
    s0 = n_abort;
    bwr(A_CTRL, 32'h0000_0002); idle(2);
    chk("R12 abort pulse", 32'(n_abort - s0), 32'd1);
    brd(A_STAT, r); chk("R12 fifos empty after disable", {30'b0, r[5], r[4]}, {30'b0, 2'b01});
    bwr(A_TXB, 32'h77); idle(1);
    chk("R12 push ignored while disabled", 32'(tx_valid), 32'd0);
    bwr(A_CTRL, 32'h0000_0003);

    // R4 events, R5 write-one-to-clear, R6 masking
    bwr(A_IEN, 32'h0000_0001);
    pulse(0); idle(1);
    chk("R6 irq from enabled tx done", 32'(irq), 32'd1);
    bwr(A_STAT, 32'h0000_0006);
    brd(A_STAT, r); chk("R5 zero bit leaves tx done set", 32'(r[0]), 32'd1);
    bwr(A_STAT, 32'h0000_0001);
    brd(A_STAT, r); chk("R5 one clears tx done", 32'(r[0]), 32'd0);
    chk("R6 irq low after clear", 32'(irq), 32'd0);
    pulse(2); pulse(1); idle(1);
    brd(A_STAT, r); chk("R4 rx avail and rx done set", {29'b0, r[2:0]}, {29'b0, 3'b110});
    chk("R6 masked events keep irq low", 32'(irq), 32'd0);
    bwr(A_IEN, 32'h0000_0010);
    chk("R6 irq from live rx empty", 32'(irq), 32'd1);
    bwr(A_IEN, 32'h0);
    bwr(A_STAT, 32'h0000_0007);
    brd(A_STAT, r); chk("R5 all sticky cleared", {29'b0, r[2:0]}, 32'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule